// File: doc/BRIEF.md
# Cascadable Four-Channel Down-Counting Timer Group

This block holds four down-counting timers, numbered 0 to 3, behind a small register bus. All four share one input clock, and one shared prescaler divides that clock. Software arms a timer by writing a reload value with its stop flag cleared. The timer then counts prescaled ticks. Each time it runs out, it gives a one-clock interrupt pulse, flips a toggle flag and reloads. It keeps doing this until the stop flag is set again.

Any two neighbouring timers can be chained. The lower timer then counts the fine ticks. The upper timer steps only when the lower one runs out, so the pair acts as one counter of about twice the width. In a chained pair only the upper timer raises its interrupt, and the upper timer's stop flag governs both halves. A per-pair rollover option makes the lower half reload to its all-ones value after each underflow instead of to its base value.

Each timer runs a two-state machine. The states are `CH_HALT` and `CH_RUN`. The *launch* transition goes from `CH_HALT` to `CH_RUN` when the effective stop flag falls, and it loads the count from the base value. The *park* transition goes from `CH_RUN` to `CH_HALT` when the effective stop flag rises, and it freezes the count.

Top module: `tmr_group`

## Requirements
- R1: After reset every register reads zero, except each base register, which reads 0x8000_0000 (stop flag set); all interrupt outputs are low.
- R2: Control bits 9:8 select the tick period as 2^(PRE_LOG+sel) clocks (8, 16, 32, 64 with the default PRE_LOG=3); any control write restarts the prescaler phase; ticks are never on consecutive clocks.
- R3: A free-running timer with base value N>=1 pulses its interrupt for exactly one clock every N ticks; a base value of 0 behaves as 1.
- R4: In the base register, bit 31 is the stop flag and the low CNT_W bits are the reload value. Clearing the stop flag from set loads the current count from the base value. Writing the base value while the timer runs changes only the next reload, not the live count.
- R5: While a timer is parked, its count stays frozen and its interrupt stays low.
- R6: Bit 31 of the current-count register is a toggle flag that flips on each expiry. Any write to the current-count register clears both the count and the toggle flag.
- R7: Control bits 0, 1 and 2 chain pairs (0,1), (1,2) and (2,3). When enabled pairs overlap, the lower-numbered pair takes precedence. The lower timer of a chained pair never pulses its interrupt.
- R8: A chained pair with lower base L>=1 and upper base H, without rollover, expires every (H+1)*L ticks.
- R9: With the pair's rollover bit set (control bits 24, 25, 26 for pairs (0,1), (1,2), (2,3)), the pair expires every L + H*(2^CNT_W - 1) ticks.
- R10: The vector and destination registers store all 32 bits. The control register reads back only bits 26:24, 9:8 and 2:0. Offsets outside the map read zero.
- R11: Timer i occupies byte offsets 0x40*i + {0x00 current count, 0x10 base, 0x20 vector, 0x30 destination}, and the control register is at 0x100. Read data appears on the clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all timers |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe; data is registered on bus_rdata |
| bus_rdata | output | 32 | Read data, valid the clock after bus_rd |
| irq_o | output | 4 | One-clock expiry pulse per timer |

## Verification
The bench builds the group with CNT_W=4 and PRE_LOG=1. With these values the four prescaler settings give ticks every 2 to 16 clocks. The rollover reload value becomes 15, so a rolled-over chained period completes in a few dozen clocks. Under these values every prescaler setting, both chaining formulas, the pair-overlap precedence and repeated toggle flips can be observed as exact pulse-to-pulse intervals, with no wait of 2^31 ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NUM_TMR = 4;
    localparam int NPAIR   = NUM_TMR - 1;
    localparam int DATA_W  = 32;

    typedef enum logic {
        CH_HALT = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    typedef enum logic [1:0] {
        RG_COUNT = 2'd0,
        RG_BASE  = 2'd1,
        RG_VEC   = 2'd2,
        RG_DEST  = 2'd3
    } reg_sel_e;

    localparam logic [31:0] CTRL_OFS   = 32'h0000_0100;
    localparam logic [31:0] TMR_SPAN   = 32'h0000_0100;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int BASE_LOG = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int PS_W = BASE_LOG + 3;

    logic [PS_W-1:0] div_q;
    logic [PS_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= '0;
        else if (restart) div_q <= '0;
        else              div_q <= div_q + 1'b1;
    end

    always_comb begin
        mask = '0;
        for (int b = 0; b < PS_W; b++) begin
            if (b < BASE_LOG + int'(sel)) mask[b] = 1'b1;
        end
    end

    assign tick = ((div_q & mask) == mask);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             step,
    input  logic             clr,
    input  logic             irq_en,
    input  logic             cas_hi,
    input  logic [CNT_W-1:0] base_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tog_q,
    output logic             run_o,
    output logic             at_end_o,
    output logic             irq_o
);
    ch_state_e st_q, st_d;
    logic      launch;
    logic      expire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_HALT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_HALT: if (!hold) st_d = CH_RUN;
            CH_RUN:  if (hold)  st_d = CH_HALT;
            default: st_d = CH_HALT;
        endcase
    end

    assign run_o    = (st_q == CH_RUN);
    assign launch   = (st_q == CH_HALT) && !hold;
    assign at_end_o = run_o && (cas_hi ? (cnt_q == '0) : (cnt_q < CNT_W'(2)));
    assign expire   = at_end_o && step;

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
            irq_o <= 1'b0;
        end else begin
            irq_o <= expire && irq_en;
            if (launch) begin
                cnt_q <= base_val;
            end else if (clr) begin
                cnt_q <= '0;
                tog_q <= 1'b0;
            end else if (expire) begin
                cnt_q <= reload_val;
                tog_q <= ~tog_q;
            end else if (run_o && step) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_group.sv
module tmr_group
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 31,
    parameter int PRE_LOG = 3,
    parameter int ADDR_W  = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_TMR-1:0]  irq_o
);
    localparam int IDX_W = $clog2(NUM_TMR);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0]   base_q [NUM_TMR];
    logic [DATA_W-1:0]  vec_q  [NUM_TMR];
    logic [DATA_W-1:0]  dest_q [NUM_TMR];
    logic [CNT_W-1:0]   cnt_arr [NUM_TMR];
    logic [NUM_TMR-1:0] inhib_q;
    logic [1:0]         psel_q;
    logic [NPAIR-1:0]   cas_q, roll_q, pair_on;
    logic [NUM_TMR-1:0] low_of, high_of, roll_x;
    logic [NUM_TMR-1:0] hold_v, step_v, clr_v, tog_v, run_v, end_v;
    logic [DATA_W-1:0]  a32, rd_mux;
    logic               hit_tmr, hit_ctrl, tick;
    logic [IDX_W-1:0]   idx;
    reg_sel_e           rsel;

    // address decode
    assign a32      = DATA_W'(bus_addr);
    assign hit_ctrl = (a32 == CTRL_OFS);
    assign hit_tmr  = (a32 < TMR_SPAN) && (a32[3:0] == 4'h0);
    assign idx      = a32[6 +: IDX_W];
    assign rsel     = reg_sel_e'(a32[5:4]);

    always_comb begin
        for (int i = 0; i < NUM_TMR; i++) begin
            clr_v[i] = bus_wr && hit_tmr && (idx == IDX_W'(i)) && (rsel == RG_COUNT);
        end
    end

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_TMR; i++) begin
                base_q[i] <= '0;
                vec_q[i]  <= '0;
                dest_q[i] <= '0;
            end
            inhib_q <= '1;
            psel_q  <= '0;
            cas_q   <= '0;
            roll_q  <= '0;
        end else if (bus_wr) begin
            if (hit_ctrl) begin
                psel_q <= bus_wdata[9:8];
                cas_q  <= bus_wdata[NPAIR-1:0];
                roll_q <= bus_wdata[24 +: NPAIR];
            end else if (hit_tmr) begin
                unique case (rsel)
                    RG_BASE: begin
                        base_q[idx]  <= bus_wdata[CNT_W-1:0];
                        inhib_q[idx] <= bus_wdata[DATA_W-1];
                    end
                    RG_VEC:  vec_q[idx]  <= bus_wdata;
                    RG_DEST: dest_q[idx] <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // read path
    always_comb begin
        rd_mux = '0;
        if (hit_ctrl) begin
            rd_mux[24 +: NPAIR] = roll_q;
            rd_mux[9:8]         = psel_q;
            rd_mux[NPAIR-1:0]   = cas_q;
        end else if (hit_tmr) begin
            unique case (rsel)
                RG_COUNT: begin
                    rd_mux           = DATA_W'(cnt_arr[idx]);
                    rd_mux[DATA_W-1] = tog_v[idx];
                end
                RG_BASE: begin
                    rd_mux           = DATA_W'(base_q[idx]);
                    rd_mux[DATA_W-1] = inhib_q[idx];
                end
                RG_VEC:  rd_mux = vec_q[idx];
                RG_DEST: rd_mux = dest_q[idx];
                default: rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // pair precedence: the lower pair wins on overlap
    always_comb begin
        pair_on[0] = cas_q[0];
        for (int k = 1; k < NPAIR; k++) pair_on[k] = cas_q[k] & ~pair_on[k-1];
    end

    assign low_of  = {1'b0, pair_on};
    assign high_of = {pair_on, 1'b0};
    assign roll_x  = {1'b0, roll_q};

    tmr_prescale #(.BASE_LOG(PRE_LOG)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (bus_wr && hit_ctrl),
        .sel     (psel_q),
        .tick    (tick)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
        logic             up_inhib, up_end, dn_end;
        logic [CNT_W-1:0] reload_c;

        if (i < NUM_TMR - 1) begin : g_up
            assign up_inhib = inhib_q[i+1];
            assign up_end   = end_v[i+1];
        end else begin : g_top
            assign up_inhib = 1'b1;
            assign up_end   = 1'b0;
        end

        if (i > 0) begin : g_dn
            assign dn_end = end_v[i-1];
        end else begin : g_bot
            assign dn_end = 1'b0;
        end

        assign hold_v[i] = low_of[i] ? up_inhib : inhib_q[i];
        assign step_v[i] = high_of[i] ? (tick && dn_end) : tick;
        assign reload_c  = (low_of[i] && roll_x[i] && !up_end) ? ALL_ONES : base_q[i];

        tmr_chan #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .hold       (hold_v[i]),
            .step       (step_v[i]),
            .clr        (clr_v[i]),
            .irq_en     (!low_of[i]),
            .cas_hi     (high_of[i]),
            .base_val   (base_q[i]),
            .reload_val (reload_c),
            .cnt_q      (cnt_arr[i]),
            .tog_q      (tog_v[i]),
            .run_o      (run_v[i]),
            .at_end_o   (end_v[i]),
            .irq_o      (irq_o[i])
        );
    end
endmodule

// File: rtl/tmr_group_chk.sv
module tmr_group_chk #(
    parameter int CNT_W = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       irq,
    input logic             tick,
    input logic             run3,
    input logic             hold3,
    input logic             clr3,
    input logic             tog3,
    input logic             low0,
    input logic [CNT_W-1:0] cnt3
);
    // R3
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |=> ((irq & $past(irq)) == 4'b0000));

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run3 && hold3 && !clr3) |=> $stable(cnt3));

    // R5
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run3) |-> !irq[3]);

    // R7
    low_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(low0) |-> !irq[0]);

    // R6
    tog_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tog3) && !$past(clr3)) |-> irq[3]);
endmodule

bind tmr_group tmr_group_chk #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .irq   (irq_o),
    .tick  (tick),
    .run3  (run_v[3]),
    .hold3 (hold_v[3]),
    .clr3  (clr_v[3]),
    .tog3  (tog_v[3]),
    .low0  (pair_on[0]),
    .cnt3  (cnt_arr[3])
);

// File: tb/tmr_group_bench.sv
module tmr_group_bench;
    localparam int CNT_W   = 4;
    localparam int PRE_LOG = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_fail = 0;

    tmr_group #(.CNT_W(CNT_W), .PRE_LOG(PRE_LOG), .ADDR_W(9)) u_tmr_group (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata), .irq_o(irq)
    );

    always #5 clk = ~clk;

    // scoreboard state
    int    exp_q[$];
    string tag_q[$];
    int    mon_ch = 3;
    bit    armed = 1'b0;
    bit    have_last = 1'b0;
    int    last_cyc = 0;
    int    cyc = 0;
    int    pulses[4] = '{0, 0, 0, 0};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // monitor: measures pulse-to-pulse intervals and pops expectations
    always @(negedge clk) begin
        int    e;
        string t;
        cyc++;
        for (int c = 0; c < 4; c++) if (irq[c]) pulses[c]++;
        if (armed && irq[mon_ch]) begin
            if (have_last && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 32'(cyc - last_cyc), 32'(e));
            end
            have_last = 1'b1;
            last_cyc  = cyc;
        end
    end

    task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    // driver: queue expected periods on one channel and wait for them
    task automatic expect_period(input int ch, input int clocks, input int n, input string tag);
        int waited;
        @(negedge clk);
        mon_ch = ch; have_last = 1'b0;
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(clocks);
            tag_q.push_back(tag);
        end
        armed = 1'b1;
        waited = 0;
        while (exp_q.size() > 0 && waited < 3000) begin
            @(negedge clk); waited++;
        end
        armed = 1'b0;
        while (exp_q.size() > 0) begin
            n_chk++; n_fail++;
            $display("FAIL %s: actual no pulse expected interval %0d", tag_q.pop_front(), exp_q.pop_front());
        end
    endtask

    task automatic wait_irq(input int ch);
        int w;
        w = 0;
        do begin @(negedge clk); w++; end while (!irq[ch] && w < 2000);
    endtask

    function automatic logic [8:0] ra(input int t, input int r);
        return 9'(t * 64 + r * 16);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int p0, p2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq after reset", 32'(irq), 32'h0);
        bus_rd(ra(3, 1), v); chk("R1 base3 reset", v, 32'h8000_0000);
        bus_rd(ra(0, 1), v); chk("R1 base0 reset", v, 32'h8000_0000);
        bus_rd(ra(0, 0), v); chk("R1 count0 reset", v, 32'h0);
        bus_rd(9'h100, v);   chk("R1 ctrl reset", v, 32'h0);

        // R10 / R11 storage, map and readback
        bus_wr(ra(1, 2), 32'hDEAD_BEEF);
        bus_wr(ra(2, 3), 32'h1234_5678);
        bus_rd(ra(1, 2), v); chk("R10 R11 vector1", v, 32'hDEAD_BEEF);
        bus_rd(ra(2, 3), v); chk("R10 R11 dest2", v, 32'h1234_5678);
        bus_rd(ra(2, 2), v); chk("R11 vector2 untouched", v, 32'h0);
        bus_rd(9'h104, v);   chk("R10 unmapped 0x104", v, 32'h0);
        bus_rd(9'h008, v);   chk("R10 unmapped 0x008", v, 32'h0);
        bus_wr(9'h100, 32'hFFFF_FFFF);
        bus_rd(9'h100, v);   chk("R10 ctrl readback", v, 32'h0700_0307);

        // R4 launch load, then write while running
        bus_wr(9'h100, 32'h0000_0300);
        bus_wr(ra(3, 1), 32'h0000_0005);
        @(negedge clk);
        bus_rd(ra(3, 0), v); chk("R4 count loaded on launch", v, 32'h5);
        bus_wr(ra(3, 1), 32'h0000_0007);
        bus_rd(ra(3, 0), v); chk("R4 running count kept", v, 32'h5);

        // R2 / R3 periods
        bus_wr(9'h100, 32'h0);
        bus_wr(ra(3, 1), 32'h5);
        expect_period(3, 10, 3, "R3 base5 div2");
        bus_wr(9'h100, 32'h0000_0100);
        expect_period(3, 20, 2, "R2 sel1 div4");
        bus_wr(9'h100, 32'h0000_0200);
        bus_wr(ra(3, 1), 32'h3);
        expect_period(3, 24, 2, "R2 sel2 div8");
        bus_wr(9'h100, 32'h0);
        bus_wr(ra(3, 1), 32'h0);
        expect_period(3, 2, 3, "R3 base zero");

        // R6 toggle and clear
        bus_wr(ra(3, 1), 32'h8000_0005);
        bus_wr(ra(3, 0), 32'h0);
        bus_rd(ra(3, 0), v); chk("R6 clear count and toggle", v, 32'h0);
        bus_wr(ra(3, 1), 32'h0000_0005);
        wait_irq(3);
        bus_rd(ra(3, 0), v); chk("R6 toggle after first expiry", {31'b0, v[31]}, 32'h1);
        wait_irq(3);
        bus_rd(ra(3, 0), v); chk("R6 toggle after second expiry", {31'b0, v[31]}, 32'h0);

        // R5 park freezes count and interrupt
        bus_wr(ra(3, 1), 32'h8000_0005);
        bus_rd(ra(3, 0), v);
        p0 = pulses[3];
        repeat (40) @(negedge clk);
        bus_rd(ra(3, 0), v2);
        chk("R5 parked count frozen", v2, v);
        chk("R5 parked no pulse", 32'(pulses[3] - p0), 32'h0);

        // R7 / R8 chained pair (2,3)
        bus_wr(9'h100, 32'h0000_0004);
        bus_wr(ra(2, 1), 32'h0000_0003);
        bus_wr(ra(3, 1), 32'h8000_0002);
        bus_wr(ra(3, 1), 32'h0000_0002);
        p2 = pulses[2];
        expect_period(3, 18, 3, "R8 chain no rollover");
        chk("R7 low half silent", 32'(pulses[2] - p2), 32'h0);

        // R9 rollover
        bus_wr(ra(3, 1), 32'h8000_0002);
        bus_wr(9'h100, 32'h0400_0004);
        bus_wr(ra(3, 1), 32'h0000_0002);
        expect_period(3, 66, 2, "R9 chain rollover");

        // R7 precedence of overlapping pairs
        bus_wr(ra(3, 1), 32'h8000_0002);
        bus_wr(9'h100, 32'h0000_0003);
        bus_wr(ra(0, 1), 32'h0000_0002);
        bus_wr(ra(1, 1), 32'h0000_0001);
        bus_wr(ra(2, 1), 32'h0000_0003);
        p0 = pulses[0];
        expect_period(1, 8, 2, "R7 R8 pair01 wins");
        expect_period(2, 6, 2, "R7 timer2 standalone");
        chk("R7 timer0 silent", 32'(pulses[0] - p0), 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule